// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers every reason the chip may need to restart into one synchronous internal reset, drives a separate reset-out pin, and keeps a record of which reason produced the most recent reset. Software reads that record after it restarts. Five of the causes arrive as level flags from outside the block: the external reset pin, the watchdog timeout, clock loss, PLL lock loss and low voltage. Each of these five passes through a synchronizer. Power-on reset is the block's own synchronous active-high reset. A software reset is requested by writing one bit of a control word.

The internal reset stays active while any cause is present. It is then stretched by a fixed number of cycles and released on a clock edge. The cause record holds exactly one flag. It is replaced only when a new reset begins, or by power-on. It therefore survives the reset it describes. The reset-out pin follows the internal reset. The exception is a reset that came in on the external pin: in that case reset-out stays low, so the board's reset net does not feed back into itself.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_in` is high at a clock edge, after that edge `rst_int_o` and `rst_out_o` are 1 and `cause_o` equals 7'b0000001. Once `por_in` falls, `rst_int_o` deasserts exactly STRETCH edges later.
- R2: `cause_o` holds one flag per cause at these bit positions: 0 power-on, 1 low voltage, 2 clock loss, 3 lock loss, 4 watchdog, 5 external pin, 6 software. When a reset begins with several causes active, only the flag with the lowest bit index is set.
- R3: While the internal reset is active, new causes do not change `cause_o`.
- R4: After the reset is released, `cause_o` keeps its value until the next reset begins.
- R5: A flag input (`pin_rst_in`, `wdog_expired`, `clk_lost`, `pll_unlocked`, `low_volt`) that goes high before edge 0 raises `rst_int_o` at edge SYNC_STAGES and not earlier. When that flag drops before edge 0, `rst_int_o` falls at edge SYNC_STAGES+STRETCH-1, which is SYNC_STAGES+STRETCH edges counted from edge 0.
- R6: `rst_out_o` equals `rst_int_o` whenever the recorded cause is not the external pin (bit 5). When the recorded cause is the external pin, `rst_out_o` stays 0.
- R7: A write (`sw_wr_en`=1) with `sw_wr_data[SW_BIT]`=1 made while no reset is active raises `rst_int_o` at the second edge and records bit 6. The reset lasts STRETCH+1 cycles. The request clears itself, so one write gives exactly one reset.
- R8: Writes with `sw_wr_data[SW_BIT]`=0 have no effect. Writes made while a reset is active are ignored.
- R9: Power-on arriving during another reset replaces `cause_o` with 7'b0000001 and drives `rst_out_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_in | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_in | input | 1 | External reset pin level, active high |
| sw_wr_en | input | 1 | Control-word write strobe |
| sw_wr_data | input | CTRL_W | Control-word write data; bit SW_BIT requests a software reset |
| wdog_expired | input | 1 | Watchdog timeout flag |
| clk_lost | input | 1 | Clock-loss flag |
| pll_unlocked | input | 1 | PLL lock-loss flag |
| low_volt | input | 1 | Low-voltage flag |
| rst_int_o | output | 1 | Internal synchronous reset |
| rst_out_o | output | 1 | Reset-out pin drive |
| cause_o | output | 7 | Last-reset cause, one-hot |

## Verification
The bench builds the block with STRETCH=5, SYNC_STAGES=3 and SW_BIT=3. The short stretch lets every release window be counted edge by edge. The three-stage synchronizer makes the rise and release latency differ clearly from the plain stretch count. A non-zero SW_BIT shows that only the chosen bit of the control word triggers a reset. With these values, priority pairs, late causes during an active reset, power-on during a reset and ignored writes all complete within a few hundred cycles.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_CAUSES = 7;
  localparam int NUM_FLAGS  = 5;
  // cause bit positions, lowest index wins
  localparam int CI_POR  = 0;
  localparam int CI_LVD  = 1;
  localparam int CI_CLK  = 2;
  localparam int CI_LOCK = 3;
  localparam int CI_WDOG = 4;
  localparam int CI_PIN  = 5;
  localparam int CI_SW   = 6;
  typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (clr) chain <= '0;
      else     chain <= (chain << 1) | STAGES'(d[i]);
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/rstc_prio.sv
module rstc_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por,
  input  logic cause_any,
  output logic rst_q,
  output logic rst_next,
  output logic entry
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q, cnt_next;

  always_comb begin
    if (cause_any)        cnt_next = CW'(HOLD);
    else if (cnt_q != '0) cnt_next = cnt_q - 1'b1;
    else                  cnt_next = '0;
    rst_next = (cnt_next != '0);
    entry    = cause_any && !rst_q;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      cnt_q <= CW'(HOLD);
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_next;
      rst_q <= rst_next;
    end
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 8,
  parameter int SW_BIT      = 0
) (
  input  logic              clk,
  input  logic              por_in,
  input  logic              pin_rst_in,
  input  logic              sw_wr_en,
  input  logic [CTRL_W-1:0] sw_wr_data,
  input  logic              wdog_expired,
  input  logic              clk_lost,
  input  logic              pll_unlocked,
  input  logic              low_volt,
  output logic              rst_int_o,
  output logic              rst_out_o,
  output logic [NUM_CAUSES-1:0] cause_o
);
  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic       sw_req_q;
  cause_vec_t cause_now, pick, status_q, status_d;
  logic       rst_q, rst_next, entry, rst_out_q;
  logic       unused_wdata;

  assign unused_wdata = ^sw_wr_data;
  assign flags_raw = {pin_rst_in, wdog_expired, pll_unlocked, clk_lost, low_volt};

  rstc_sync #(.W(NUM_FLAGS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .clr(por_in), .d(flags_raw), .q(flags_s)
  );

  // software request: cleared once reset is in effect, writes during reset dropped
  always_ff @(posedge clk) begin
    if (por_in || rst_q)                         sw_req_q <= 1'b0;
    else if (sw_wr_en && sw_wr_data[SW_BIT])     sw_req_q <= 1'b1;
  end

  assign cause_now = {sw_req_q, flags_s, 1'b0};

  rstc_prio #(.N(NUM_CAUSES)) prio_i (.req(cause_now), .grant(pick));

  rstc_stretch #(.HOLD(STRETCH)) stretch_i (
    .clk(clk), .por(por_in), .cause_any(|cause_now),
    .rst_q(rst_q), .rst_next(rst_next), .entry(entry)
  );

  assign status_d = entry ? pick : status_q;

  always_ff @(posedge clk) begin
    if (por_in) begin
      status_q  <= cause_vec_t'(1) << CI_POR;
      rst_out_q <= 1'b1;
    end else begin
      status_q  <= status_d;
      rst_out_q <= rst_next && !status_d[CI_PIN];
    end
  end

  assign rst_int_o = rst_q;
  assign rst_out_o = rst_out_q;
  assign cause_o   = status_q;
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk
  import rstc_pkg::*;
(
  input logic       clk,
  input logic       por_in,
  input logic       sw_wr_en,
  input logic       sw_bit,
  input logic       rst_int_o,
  input logic       rst_out_o,
  input logic [NUM_CAUSES-1:0] cause_o
);
  assert_status_onehot_R2: assert property (@(posedge clk) disable iff (por_in)
    $countones(cause_o) == 1);

  assert_status_frozen_R3: assert property (@(posedge clk) disable iff (por_in)
    (rst_int_o && !por_in) |=> ($stable(cause_o) || por_in));

  assert_status_kept_R4: assert property (@(posedge clk) disable iff (por_in)
    (!rst_int_o && !por_in) |=> ($stable(cause_o) || rst_int_o));

  assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (por_in)
    (rst_int_o && cause_o[CI_PIN]) |-> !rst_out_o);

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (por_in)
    (rst_int_o && !cause_o[CI_PIN]) |-> rst_out_o);

  assert_out_idle_R6: assert property (@(posedge clk) disable iff (por_in)
    !rst_int_o |-> !rst_out_o);

  assert_sw_trigger_R7: assert property (@(posedge clk) disable iff (por_in)
    (sw_wr_en && sw_bit && !rst_int_o) |=> ##1 rst_int_o);
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk chk_i (
  .clk(clk), .por_in(por_in), .sw_wr_en(sw_wr_en), .sw_bit(sw_wr_data[SW_BIT]),
  .rst_int_o(rst_int_o), .rst_out_o(rst_out_o), .cause_o(cause_o)
);

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
  localparam int STRETCH = 5;
  localparam int SYNC    = 3;
  localparam int CTRL_W  = 8;
  localparam int SW_BIT  = 3;

  logic clk = 1'b0;
  logic por_in = 1'b1;
  logic pin_rst_in = 0, sw_wr_en = 0, wdog_expired = 0, clk_lost = 0;
  logic pll_unlocked = 0, low_volt = 0;
  logic [CTRL_W-1:0] sw_wr_data = '0;
  logic rst_int_o, rst_out_o;
  logic [6:0] cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.STRETCH(STRETCH), .SYNC_STAGES(SYNC), .CTRL_W(CTRL_W),
                   .SW_BIT(SW_BIT)) dut_i (
    .clk(clk), .por_in(por_in), .pin_rst_in(pin_rst_in), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .wdog_expired(wdog_expired), .clk_lost(clk_lost),
    .pll_unlocked(pll_unlocked), .low_volt(low_volt),
    .rst_int_o(rst_int_o), .rst_out_o(rst_out_o), .cause_o(cause_o)
  );

  // {flags pin,wdog,lock,clk,lvd ; expected cause ; expected rst_out}
  localparam logic [12:0] VEC [9] = '{
    {5'b00001, 7'b0000010, 1'b1},
    {5'b00010, 7'b0000100, 1'b1},
    {5'b00100, 7'b0001000, 1'b1},
    {5'b01000, 7'b0010000, 1'b1},
    {5'b10000, 7'b0100000, 1'b0},
    {5'b01001, 7'b0000010, 1'b1},
    {5'b11000, 7'b0010000, 1'b1},
    {5'b00110, 7'b0000100, 1'b1},
    {5'b10100, 7'b0001000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [4:0] m);
    {pin_rst_in, wdog_expired, pll_unlocked, clk_lost, low_volt} = m;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // counts edges until rst_int_o is seen low
  task automatic count_release(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!rst_int_o) break;
    end
  endtask

  task automatic sw_write(input logic [CTRL_W-1:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    @(posedge clk); @(negedge clk);
    sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    // R1 power-on
    edges(3);
    chk(rst_int_o == 1, "R1 rst_int", rst_int_o, 1);
    chk(rst_out_o == 1, "R1 rst_out", rst_out_o, 1);
    chk(cause_o == 7'b0000001, "R1 cause", cause_o, 1);
    por_in = 0;
    count_release(n);
    chk(n == STRETCH, "R1 release", n, STRETCH);
    chk(cause_o == 7'b0000001, "R4 por kept", cause_o, 1);

    // table: R2 R5 R6 R4
    foreach (VEC[k]) begin
      logic [4:0] m; logic [6:0] ec; logic eo;
      {m, ec, eo} = VEC[k];
      set_flags(m);
      edges(SYNC);
      chk(rst_int_o == 0, "R5 no early rise", rst_int_o, 0);
      edges(1);
      chk(rst_int_o == 1, "R5 rise", rst_int_o, 1);
      chk(cause_o == ec, "R2 cause", cause_o, ec);
      chk(rst_out_o == eo, "R6 rst_out", rst_out_o, eo);
      edges(2);
      set_flags('0);
      count_release(n);
      chk(n == SYNC + STRETCH, "R5 release", n, SYNC + STRETCH);
      chk(rst_out_o == 0, "R6 out idle", rst_out_o, 0);
      edges(4);
      chk(cause_o == ec, "R4 kept", cause_o, ec);
    end

    // R7 software reset
    sw_write(CTRL_W'(1) << SW_BIT);
    chk(rst_int_o == 0, "R7 not yet", rst_int_o, 0);
    edges(1);
    chk(rst_int_o == 1, "R7 rise", rst_int_o, 1);
    chk(cause_o == 7'b1000000, "R7 cause", cause_o, 7'h40);
    chk(rst_out_o == 1, "R7 rst_out", rst_out_o, 1);
    count_release(n);
    chk(n == STRETCH + 1, "R7 length", n, STRETCH + 1);
    edges(10);
    chk(rst_int_o == 0, "R7 self-clear", rst_int_o, 0);

    // R8 other bits do nothing
    sw_write(~(CTRL_W'(1) << SW_BIT));
    edges(10);
    chk(rst_int_o == 0, "R8 other bits", rst_int_o, 0);
    chk(cause_o == 7'b1000000, "R8 cause untouched", cause_o, 7'h40);

    // R8 write during reset ignored, R3 late cause ignored
    set_flags(5'b01000);
    edges(SYNC + 1);
    sw_write(CTRL_W'(1) << SW_BIT);
    set_flags(5'b01001);
    edges(SYNC + 2);
    chk(cause_o == 7'b0010000, "R3 late cause", cause_o, 7'h10);
    set_flags('0);
    count_release(n);
    edges(10);
    chk(rst_int_o == 0, "R8 write in reset", rst_int_o, 0);
    chk(cause_o == 7'b0010000, "R8 cause after", cause_o, 7'h10);

    // R3 with pin reset then watchdog, R6 stays low
    set_flags(5'b10000);
    edges(SYNC + 1);
    set_flags(5'b11000);
    edges(SYNC + 2);
    chk(cause_o == 7'b0100000, "R3 pin kept", cause_o, 7'h20);
    chk(rst_out_o == 0, "R6 pin quiet", rst_out_o, 0);

    // R9 power-on during reset
    por_in = 1;
    edges(1);
    chk(cause_o == 7'b0000001, "R9 cause", cause_o, 1);
    chk(rst_out_o == 1, "R9 rst_out", rst_out_o, 1);
    set_flags('0);
    por_in = 0;
    count_release(n);
    chk(n == STRETCH, "R9 release", n, STRETCH);
    finish_run();
  end
endmodule